// File: doc/BRIEF.md
# Register-Launched I2C Single-Byte Master

This block runs one complete I2C transaction at a time on behalf of a processor or simple button logic. The command is written one byte at a time through four byte lanes. Lanes 3, 2 and 1 hold the transfer direction, the 7-bit target address and the register index. They may be written in any order and keep their contents between transactions. A write to lane 0 supplies the data byte and starts the transfer on the bus.

A write transaction sends the register index and then the data byte to the target. A read transaction first sets the target's register pointer. It then issues a repeated start, collects one byte, answers that byte with NACK and stops.

The block reports its progress on four outputs: `busy`, a one-cycle `done` pulse, the byte that was read, and a flag that records a missing acknowledge. SCL and SDA are open-drain: each output asks for its line to be pulled low, and a released line reads high through the external pull-up. There is no clock stretching, no arbitration and no multi-byte burst.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both lines are released, and `busy`, `done`, `ack_err` and `rd_data` are all zero.
- R2: Lane 3 bit 7 selects the direction (1 = read, 0 = write). Lane 2 bits 6:0 give the target address and lane 1 gives the register index; these three lanes may be written in any order. A lane 0 write while idle launches a transaction with lane 0 as the data byte, and `busy` is high in the following cycle.
- R3: Every SCL period during a transaction lasts 4*QTR_CYC system clocks, where QTR_CYC = CLK_HZ/(4*SCL_HZ). The default is 100 kHz.
- R4: A write sends one start, then address with R/W=0, register index, data byte, then stop. The addressed register of the target ends up holding the data byte.
- R5: A read sends start, address with R/W=0, register index, a repeated start, address with R/W=1, then clocks in one byte. The master releases SDA on the ninth bit (NACK) and then stops. The byte appears on `rd_data`, and the master never pulls SDA low during the received byte.
- R6: While SCL is high, SDA changes only to form a start, repeated start or stop condition.
- R7: If an acknowledge bit reads high, `ack_err` is set, the transfer ends with a stop and `done` still pulses. `ack_err` clears at the next launch.
- R8: `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R9: A lane 0 write while `busy` is high is dropped. It changes neither the running transfer nor any later one, and it starts nothing.
- R10: A lane 0 write presented in the cycle in which `done` is high is accepted as a new launch.
- R11: Lanes 3 to 1 may be rewritten while busy without disturbing the running transfer. Their held values are reused when only lane 0 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte-lane write strobe |
| wr_lane | input | 2 | Lane selected by the write (0 launches) |
| wr_byte | input | 8 | Byte written to the selected lane |
| sda_in | input | 1 | Level of the SDA line as seen on the pin |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| rd_data | output | 8 | Byte returned by the last successful read |
| ack_err | output | 1 | The last transaction saw a missing acknowledge |

## Verification
The end of one transaction and the launch of the next can fall in the same clock cycle. The `done` pulse and a lane 0 write coincide, so the idle check and the capture of the new command must agree.

The bench provokes this by preloading the next command into lanes 3 to 1 while the first transfer is still running. It watches `done` between edges and asserts the lane 0 write in exactly that cycle. It expects `busy` high one cycle later, and a correct read-back of the byte the first transfer wrote. The opposite case is also covered: a lane 0 write placed in the middle of a transfer must leave the target's registers and the bus activity unchanged.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_RX,
    ST_STOP
  } bus_st_e;

  typedef enum logic [2:0] {
    SQ_ADDR_W,
    SQ_REG,
    SQ_DATA,
    SQ_ADDR_R,
    SQ_READ
  } seq_e;

  typedef struct packed {
    logic       rd;
    logic [6:0] dev;
    logic [7:0] idx;
    logic [7:0] wdat;
  } cmd_t;

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned QTR_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  generate
    if (QTR_CYC > 1) begin : g_gap_chk
      // R3: quarter ticks never come back to back
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2c_cmd_lanes.sv
module i2c_cmd_lanes
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_lane,
  input  logic [7:0] wr_byte,
  input  logic       busy,
  output cmd_t       cmd,
  output logic       launch
);

  logic       dir_q, dir_d;
  logic [6:0] dev_q, dev_d;
  logic [7:0] idx_q, idx_d;

  always_comb begin
    dir_d = dir_q;
    dev_d = dev_q;
    idx_d = idx_q;
    if (wr_en) begin
      case (wr_lane)
        2'd3:    dir_d = wr_byte[7];
        2'd2:    dev_d = wr_byte[6:0];
        2'd1:    idx_d = wr_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      dev_q <= '0;
      idx_q <= '0;
    end else begin
      dir_q <= dir_d;
      dev_q <= dev_d;
      idx_q <= idx_d;
    end
  end

  assign launch   = wr_en && (wr_lane == 2'd0) && !busy;
  assign cmd.rd   = dir_q;
  assign cmd.dev  = dev_q;
  assign cmd.idx  = idx_q;
  assign cmd.wdat = wr_byte;

endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       launch,
  input  cmd_t       cmd,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_err
);

  bus_st_e    st_q, st_d;
  seq_e       sq_q, sq_d;
  logic [1:0] q_q, q_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  cmd_t       cmd_q, cmd_d;
  logic       nack_q, nack_d;
  logic       err_q, err_d;
  logic [7:0] rd_q, rd_d;
  logic       done_q, done_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       bitph_q, bitph_d;

  // sequencing, advanced once per quarter SCL period
  always_comb begin
    st_d   = st_q;
    sq_d   = sq_q;
    q_d    = q_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    cmd_d  = cmd_q;
    nack_d = nack_q;
    err_d  = err_q;
    rd_d   = rd_q;
    done_d = 1'b0;
    if (st_q == ST_IDLE) begin
      if (launch) begin
        cmd_d  = cmd;
        st_d   = ST_START;
        sq_d   = SQ_ADDR_W;
        q_d    = 2'd0;
        err_d  = 1'b0;
        nack_d = 1'b0;
      end
    end else if (tick) begin
      q_d = q_q + 2'd1;
      case (st_q)
        ST_START: begin
          if (q_q == 2'd3) begin
            st_d  = ST_TX;
            bit_d = 4'd0;
            sh_d  = {cmd_q.dev, (sq_q == SQ_ADDR_R)};
          end
        end
        ST_TX: begin
          if (q_q == 2'd2 && bit_q == 4'd8) nack_d = sda_in;
          if (q_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
            end else begin
              bit_d = 4'd0;
              if (nack_q) begin
                err_d = 1'b1;
                st_d  = ST_STOP;
              end else begin
                case (sq_q)
                  SQ_ADDR_W: begin
                    sq_d = SQ_REG;
                    sh_d = cmd_q.idx;
                  end
                  SQ_REG: begin
                    if (cmd_q.rd) begin
                      sq_d = SQ_ADDR_R;
                      st_d = ST_START;
                    end else begin
                      sq_d = SQ_DATA;
                      sh_d = cmd_q.wdat;
                    end
                  end
                  SQ_ADDR_R: begin
                    sq_d = SQ_READ;
                    st_d = ST_RX;
                  end
                  default: st_d = ST_STOP;
                endcase
              end
            end
          end
        end
        ST_RX: begin
          if (q_q == 2'd2 && bit_q != 4'd8) sh_d = {sh_q[6:0], sda_in};
          if (q_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              bit_d = bit_q + 4'd1;
            end else begin
              bit_d = 4'd0;
              rd_d  = sh_q;
              st_d  = ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (q_q == 2'd3) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // line levels per state and quarter (1 = pull low)
  always_comb begin
    scl_d   = 1'b0;
    sda_d   = 1'b0;
    bitph_d = (st_q == ST_TX) || (st_q == ST_RX);
    case (st_q)
      ST_START: begin
        case (q_q)
          2'd0:    begin scl_d = scl_q; sda_d = 1'b0; end
          2'd1:    begin scl_d = 1'b0;  sda_d = 1'b0; end
          2'd2:    begin scl_d = 1'b0;  sda_d = 1'b1; end
          default: begin scl_d = 1'b1;  sda_d = 1'b1; end
        endcase
      end
      ST_TX: begin
        scl_d = (q_q == 2'd0) || (q_q == 2'd3);
        sda_d = (bit_q != 4'd8) ? !sh_q[7] : 1'b0;
      end
      ST_RX: begin
        scl_d = (q_q == 2'd0) || (q_q == 2'd3);
        sda_d = 1'b0;
      end
      ST_STOP: begin
        case (q_q)
          2'd0:    begin scl_d = 1'b1; sda_d = 1'b1; end
          2'd1:    begin scl_d = 1'b0; sda_d = 1'b1; end
          default: begin scl_d = 1'b0; sda_d = 1'b0; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sq_q    <= SQ_ADDR_W;
      q_q     <= 2'd0;
      bit_q   <= 4'd0;
      sh_q    <= '0;
      cmd_q   <= '0;
      nack_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      bitph_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sq_q    <= sq_d;
      q_q     <= q_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      cmd_q   <= cmd_d;
      nack_q  <= nack_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      bitph_q <= bitph_d;
    end
  end

  assign scl_low = scl_q;
  assign sda_low = sda_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rd_q;
  assign ack_err = err_q;

  // R6: inside data/ack bits SDA holds while SCL stays released
  a_r6_sda_hold_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bitph_q && $past(bitph_q) && !scl_q && $past(!scl_q)) |-> (sda_q == $past(sda_q)));

  // R5: the master never pulls SDA while a byte is being received
  a_r5_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX) |-> !sda_q);

  // R7: an acknowledge error leads straight into the stop sequence
  a_r7_err_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (st_q == ST_STOP));

  // R8: done is one cycle wide and coincides with idle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned SCL_HZ = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_lane,
  input  logic [7:0] wr_byte,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_err
);

  localparam int unsigned QTR_CYC = CLK_HZ / (4 * SCL_HZ);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       tick;
  logic       launch;
  cmd_t       cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  i2c_qtick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (busy),
    .tick  (tick)
  );

  i2c_cmd_lanes u_lanes (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_lane (wr_lane),
    .wr_byte (wr_byte),
    .busy    (busy),
    .cmd     (cmd),
    .launch  (launch)
  );

  i2c_seq_engine u_eng (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick),
    .launch  (launch),
    .cmd     (cmd),
    .sda_in  (sda_in),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ack_err (ack_err)
  );

  // R2: an accepted launch makes the block busy on the next cycle
  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!core_rst_n)
    launch |=> busy);

  // R9: no launch is produced while a transfer runs
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!core_rst_n)
    busy |-> !launch);

endmodule

// File: tb/i2c_cmd_master_bench.sv
`timescale 1ns/1ps
module i2c_cmd_master_bench;

  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned SCL_HZ = 10_000_000;
  localparam int PER = 4 * (CLK_HZ / (4 * SCL_HZ));
  localparam logic [6:0] RTC = 7'h6F;

  typedef struct packed {
    logic       rd;
    logic [6:0] dev;
    logic [7:0] idx;
    logic [7:0] dat;
    logic [7:0] exp_rd;
    logic       exp_err;
    logic [1:0] exp_starts;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 7'h6F, 8'h03, 8'h5A, 8'h00, 1'b0, 2'd1},
    '{1'b1, 7'h6F, 8'h03, 8'h00, 8'h5A, 1'b0, 2'd2},
    '{1'b0, 7'h6F, 8'h07, 8'hC3, 8'h00, 1'b0, 2'd1},
    '{1'b1, 7'h6F, 8'h07, 8'h00, 8'hC3, 1'b0, 2'd2},
    '{1'b0, 7'h2A, 8'h00, 8'h11, 8'h00, 1'b1, 2'd1},
    '{1'b1, 7'h2A, 8'h00, 8'h00, 8'h00, 1'b1, 2'd1},
    '{1'b1, 7'h6F, 8'h03, 8'h00, 8'h5A, 1'b0, 2'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_lane = 2'd0;
  logic [7:0] wr_byte = 8'h00;
  logic       scl_low, sda_low, busy, done, ack_err;
  logic [7:0] rd_data;
  logic       slv_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_low;
  assign sda_line = !(sda_low || slv_low);

  i2c_cmd_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_i2c_cmd_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_lane (wr_lane),
    .wr_byte (wr_byte),
    .sda_in  (sda_line),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ack_err (ack_err)
  );

  always #2.5 clk = !clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // bus observer and clock-chip target model
  int n_start = 0, n_stop = 0, n_hichg = 0, n_done = 0;
  int gap_min = 1 << 30, gap_max = 0;
  int sec_req = 0;
  logic [7:0] mem [16];

  initial begin
    int cyc = 0, prev_rise = -1, bcnt = 0, phase = 0, sec_seen = 0;
    bit p_scl = 1'b1, p_sda = 1'b1, in_x = 1'b0, txm = 1'b0, go_tx = 1'b0;
    logic [7:0] sh = 8'h00, ptr = 8'h00;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (done) n_done++;
      if (sec_req != sec_seen) begin
        sec_seen = sec_req;
        if (mem[0][7]) mem[0] = {1'b1, mem[0][6:0] + 7'd1};
      end
      if (p_scl && scl_line && (p_sda != sda_line)) n_hichg++;
      if (p_scl && scl_line && p_sda && !sda_line) begin
        n_start++; in_x = 1'b1; bcnt = 0; phase = 0; txm = 1'b0; go_tx = 1'b0; slv_low = 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        n_stop++; in_x = 1'b0; slv_low = 1'b0; prev_rise = -1;
      end else if (!p_scl && scl_line) begin
        if (prev_rise >= 0) begin
          if (cyc - prev_rise < gap_min) gap_min = cyc - prev_rise;
          if (cyc - prev_rise > gap_max) gap_max = cyc - prev_rise;
        end
        prev_rise = cyc;
        if (in_x) begin
          if (bcnt < 8 && !txm) sh = {sh[6:0], sda_line};
          bcnt++;
        end
      end else if (p_scl && !scl_line && in_x) begin
        if (bcnt == 8) begin
          if (!txm) begin
            if (phase == 0) begin
              if (sh[7:1] == RTC) begin
                slv_low = 1'b1; go_tx = sh[0]; phase = 1;
              end else begin
                in_x = 1'b0;
              end
            end else if (phase == 1) begin
              ptr = sh; slv_low = 1'b1; phase = 2;
            end else begin
              mem[ptr[3:0]] = sh; ptr = ptr + 8'd1; slv_low = 1'b1;
            end
          end else begin
            slv_low = 1'b0;
          end
        end else if (bcnt == 9) begin
          bcnt = 0; slv_low = 1'b0;
          if (go_tx && !txm) begin
            txm = 1'b1; sh = mem[ptr[3:0]]; slv_low = !sh[7];
          end
        end else if (txm && bcnt >= 1 && bcnt < 8) begin
          slv_low = !sh[7 - bcnt];
        end
      end
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_lane(input logic [1:0] lane, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_lane = lane; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(output bit busy_at_done);
    while (!done) @(negedge clk);
    busy_at_done = busy;
    @(negedge clk);
  endtask

  task automatic issue(input logic rd, input logic [6:0] dev, input logic [7:0] idx,
                       input logic [7:0] dat, output bit busy_at_done);
    put_lane(2'd3, {rd, 7'h00});
    put_lane(2'd2, {1'b0, dev});
    put_lane(2'd1, idx);
    put_lane(2'd0, dat);
    wait_done(busy_at_done);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    bit bz;
    int s0, p0, h0, d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!scl_low && !sda_low, "R1 lines released", {scl_low, sda_low}, 0);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    chk(!ack_err && rd_data == 8'h00, "R1 err/rd_data", {ack_err, rd_data}, 0);

    // table walk: R4 writes, R5 reads, R7 missing acknowledge, R6/R8 per transfer
    for (int v = 0; v < 7; v++) begin
      s0 = n_start; p0 = n_stop; h0 = n_hichg; d0 = n_done;
      issue(VECS[v].rd, VECS[v].dev, VECS[v].idx, VECS[v].dat, bz);
      @(negedge clk);
      chk(ack_err == VECS[v].exp_err, "R7 ack_err", ack_err, VECS[v].exp_err);
      chk(n_start - s0 == int'(VECS[v].exp_starts), VECS[v].rd ? "R5 start count" : "R4 start count",
          n_start - s0, VECS[v].exp_starts);
      chk(n_stop - p0 == 1, "R4 one stop", n_stop - p0, 1);
      chk(n_hichg - h0 == (n_start - s0) + (n_stop - p0), "R6 sda edges with scl high",
          n_hichg - h0, (n_start - s0) + (n_stop - p0));
      chk(!bz && n_done - d0 == 1, "R8 single done with busy low", {bz, 8'(n_done - d0)}, 1);
      if (VECS[v].rd && !VECS[v].exp_err)
        chk(rd_data == VECS[v].exp_rd, "R5 read byte", rd_data, VECS[v].exp_rd);
    end
    chk(mem[3] == 8'h5A && mem[7] == 8'hC3, "R4 target registers", {mem[3], mem[7]}, 16'h5AC3);
    chk(gap_min == PER && gap_max == PER, "R3 scl period", {gap_min[15:0], gap_max[15:0]}, {PER[15:0], PER[15:0]});

    // R2 lanes in another order
    put_lane(2'd1, 8'h09);
    put_lane(2'd3, 8'h00);
    put_lane(2'd2, {1'b0, RTC});
    @(negedge clk);
    chk(!busy, "R2 lanes 3..1 do not launch", busy, 0);
    wr_en = 1'b1; wr_lane = 2'd0; wr_byte = 8'hA7;
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy, "R2 busy after lane 0", busy, 1);
    wait_done(bz);
    chk(mem[9] == 8'hA7, "R2 write via reordered lanes", mem[9], 8'hA7);

    // R11 reuse held lanes, only lane 0 rewritten
    put_lane(2'd0, 8'h3C);
    wait_done(bz);
    chk(mem[9] == 8'h3C, "R11 held lanes reused", mem[9], 8'h3C);

    // R9 lane 0 write while busy is dropped
    issue(1'b0, RTC, 8'h06, 8'h44, bz);
    put_lane(2'd0, 8'h44);
    s0 = n_start;
    repeat (60) @(negedge clk);
    put_lane(2'd0, 8'h99);
    wait_done(bz);
    repeat (100) @(negedge clk);
    chk(!busy && n_start - s0 == 1, "R9 no extra launch", {busy, 8'(n_start - s0)}, 1);
    chk(mem[6] == 8'h44, "R9 running data unchanged", mem[6], 8'h44);

    // R10 launch in the done cycle, R11 lanes rewritten while busy
    put_lane(2'd3, 8'h00);
    put_lane(2'd2, {1'b0, RTC});
    put_lane(2'd1, 8'h01);
    put_lane(2'd0, 8'h33);
    put_lane(2'd3, 8'h80);
    while (!done) @(negedge clk);
    wr_en = 1'b1; wr_lane = 2'd0; wr_byte = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy, "R10 launch accepted on done", busy, 1);
    wait_done(bz);
    chk(mem[1] == 8'h33, "R11 running write kept its direction", mem[1], 8'h33);
    chk(rd_data == 8'h33 && !ack_err, "R10 read after back-to-back launch", rd_data, 8'h33);

    // R4/R5 with the clock chip: stopped then running seconds
    issue(1'b0, RTC, 8'h00, 8'h00, bz);
    sec_req++;
    repeat (3) @(negedge clk);
    issue(1'b1, RTC, 8'h00, 8'h00, bz);
    chk(rd_data == 8'h00, "R5 seconds stay stopped", rd_data, 8'h00);
    issue(1'b0, RTC, 8'h00, 8'h80, bz);
    sec_req++;
    repeat (3) @(negedge clk);
    issue(1'b1, RTC, 8'h00, 8'h00, bz);
    chk(rd_data == 8'h81, "R5 seconds ticking", rd_data, 8'h81);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule